// File: doc/BRIEF.md
# Signed Fixed-Point Divider

This block divides one signed two's-complement fixed-point number by another and returns a signed fixed-point quotient. The two operands may carry different numbers of fractional bits, and the quotient carries its own fractional count. All three counts are parameters. The sign of each operand is removed first. The binary points are then lined up by shifting the operand with fewer fractional bits left, and the dividend is widened by the number of fractional bits wanted in the quotient. After that the division is a plain unsigned integer division. The sign is put back on the quotient at the end.

The integer division is a restoring shift-subtract loop. It yields one quotient bit per clock, so an accepted operation takes one cycle per bit of the widened dividend. The caller raises `start` for one cycle with both operands valid. `busy` stays high while the loop runs. `done` then pulses for a single cycle, and from that cycle on the result ports hold their values until the next accepted start. A divisor of zero skips the loop: it raises a flag and returns a quotient of all ones.

With AL = max(A_F, B_F), the widened dividend is NW = A_W + AL − A_F + Q_F bits wide, and the quotient port is NW + 1 bits wide.

Top module: `sfx_divider`

## Requirements
- R1: For a nonzero divisor, the magnitude of the quotient equals floor(|dividend| · 2^Q_F / |divisor|), where both operands are taken as real values with A_F and B_F fractional bits. The result is therefore truncated toward zero.
- R2: The quotient is an (NW+1)-bit two's-complement number with Q_F fractional bits. It is negative (the magnitude negated) exactly when one operand is negative and the other is not.
- R3: Operands with unequal fractional counts (A_F ≠ B_F) are aligned before dividing, so the result depends only on the real values of the operands.
- R4: With a nonzero divisor, an accepted start raises `busy` from the next cycle. `done` rises exactly NW cycles after the start edge, and `busy` falls in that same cycle.
- R5: `done` is high for exactly one cycle per accepted operation.
- R6: `start` is ignored while `busy` is high. The operation in flight completes with its original operands.
- R7: A zero divisor sets `div_by_zero`, drives the quotient to all ones and pulses `done` in the cycle after the start edge, and `busy` never rises. The next accepted start clears the flag.
- R8: `rem_nz` is 1 when the integer remainder of the widened division is nonzero, and 0 otherwise. It is 0 after a divide by zero.
- R9: Between operations, `quotient`, `rem_nz` and `div_by_zero` hold their values.
- R10: After reset, `busy`, `done`, `quotient`, `rem_nz` and `div_by_zero` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a division with the present operands |
| dividend | input | A_W | Signed dividend with A_F fractional bits |
| divisor | input | B_W | Signed divisor with B_F fractional bits |
| busy | output | 1 | Division loop in progress |
| done | output | 1 | One-cycle completion pulse |
| quotient | output | NW+1 | Signed quotient with Q_F fractional bits |
| rem_nz | output | 1 | Integer remainder was nonzero (result is inexact) |
| div_by_zero | output | 1 | Last operation had a zero divisor |

## Verification
An error in the running remainder or in the shifted dividend corrupts every quotient bit after it. It therefore shows as a wrong quotient, and usually a wrong `rem_nz`, at the single `done` cycle that ends that operation, NW cycles after start. An error in the iteration counter shows even sooner, as a `done` that arrives off the NW-cycle mark. A lost sign bit or a misplaced alignment shift shows only for particular operand signs or magnitudes. For that reason every operand pair of a small configuration is swept. A separate configuration with unequal fractional counts on the operands is checked against a worked case.

// File: rtl/sfx_divider.sv
module sfx_divider #(
  parameter int A_W = 8,
  parameter int A_F = 4,
  parameter int B_W = 6,
  parameter int B_F = 3,
  parameter int Q_F = 5,
  localparam int AL   = (A_F > B_F) ? A_F : B_F,
  localparam int SH_A = AL - A_F + Q_F,
  localparam int SH_B = AL - B_F,
  localparam int NW   = A_W + SH_A,
  localparam int DW   = B_W + SH_B,
  localparam int QW   = NW + 1,
  localparam int CW   = $clog2(NW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [A_W-1:0] dividend,
  input  logic [B_W-1:0] divisor,
  output logic          busy,
  output logic          done,
  output logic [QW-1:0] quotient,
  output logic          rem_nz,
  output logic          div_by_zero
);

  logic [A_W-1:0] mag_a;
  logic [B_W-1:0] mag_b;
  logic [NW-1:0]  ext_a;
  logic [DW-1:0]  ext_b;

  assign mag_a = dividend[A_W-1] ? (~dividend + 1'b1) : dividend;
  assign mag_b = divisor[B_W-1]  ? (~divisor + 1'b1)  : divisor;
  assign ext_a = NW'(mag_a) << SH_A;
  assign ext_b = DW'(mag_b) << SH_B;

  logic [NW-1:0] n;
  logic [DW-1:0] d;
  logic [DW-1:0] r;
  logic [CW-1:0] cnt;
  logic          neg;

  logic [DW:0]   trial;
  logic          fits;
  logic [DW-1:0] r_next;
  logic [NW-1:0] q_next;
  logic [QW-1:0] q_mag;
  logic [QW-1:0] q_signed;
  logic          last;

  assign trial    = {r, n[NW-1]};
  assign fits     = trial >= {1'b0, d};
  assign r_next   = fits ? DW'(trial - {1'b0, d}) : trial[DW-1:0];
  assign q_next   = {n[NW-2:0], fits};
  assign q_mag    = {1'b0, q_next};
  assign q_signed = neg ? (~q_mag + 1'b1) : q_mag;
  assign last     = (cnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n           <= '0;
      d           <= '0;
      r           <= '0;
      cnt         <= '0;
      neg         <= 1'b0;
      busy        <= 1'b0;
      done        <= 1'b0;
      quotient    <= '0;
      rem_nz      <= 1'b0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        n   <= q_next;
        r   <= r_next;
        cnt <= cnt - 1'b1;
        if (last) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          quotient <= q_signed;
          rem_nz   <= |r_next;
        end
      end else if (start) begin
        div_by_zero <= (mag_b == '0);
        if (mag_b == '0) begin
          quotient <= '1;
          rem_nz   <= 1'b0;
          done     <= 1'b1;
        end else begin
          busy <= 1'b1;
          n    <= ext_a;
          d    <= ext_b;
          r    <= '0;
          cnt  <= CW'(NW);
          neg  <= dividend[A_W-1] ^ divisor[B_W-1];
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R5
  AST_BUSY_ENDS_DONE: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> done); // R4
  AST_START_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy && mag_b != '0) |=> busy && cnt == CW'(NW)); // R4
  AST_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n) (busy && !last) |=> busy && $stable(d) && $stable(neg)); // R6
  AST_REM_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy |-> r < d); // R1
  AST_DBZ_ONES: assert property (@(posedge clk) disable iff (!rst_n) div_by_zero |-> (&quotient) && !busy && !rem_nz); // R7
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(quotient) && $stable(rem_nz) && $stable(div_by_zero)); // R9

endmodule

// File: tb/sfx_divider_tb.sv
module sfx_divider_tb_top;
  localparam int AW = 6, AF = 3, BW = 5, BF = 1, QF = 3;
  localparam int NW = 9, QW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [AW-1:0] a = '0;
  logic [BW-1:0] b = '0;
  logic busy, done, rem_nz, dbz;
  logic [QW-1:0] quo;

  logic x_start = 1'b0;
  logic [6:0] x_a = '0;
  logic [3:0] x_b = '0;
  logic x_busy, x_done, x_rem_nz, x_dbz;
  logic [12:0] x_quo;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  sfx_divider #(.A_W(AW), .A_F(AF), .B_W(BW), .B_F(BF), .Q_F(QF)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(a), .divisor(b),
    .busy(busy), .done(done), .quotient(quo), .rem_nz(rem_nz), .div_by_zero(dbz));

  sfx_divider #(.A_W(7), .A_F(5), .B_W(4), .B_F(3), .Q_F(5)) dut_x (
    .clk(clk), .rst_n(rst_n), .start(x_start), .dividend(x_a), .divisor(x_b),
    .busy(x_busy), .done(x_done), .quotient(x_quo), .rem_nz(x_rem_nz), .div_by_zero(x_dbz));

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_q(input int ia, input int ib);
    int ma = (ia < 0) ? -ia : ia;
    int mb = (ib < 0) ? -ib : ib;
    int m = (ma * (1 << (3 - AF + QF))) / (mb * (1 << (3 - BF)));
    int v = ((ia < 0) != (ib < 0)) ? -m : m;
    return v & ((1 << QW) - 1);
  endfunction

  function automatic int exp_nz(input int ia, input int ib);
    int ma = (ia < 0) ? -ia : ia;
    int mb = (ib < 0) ? -ib : ib;
    return (((ma * (1 << (3 - AF + QF))) % (mb * (1 << (3 - BF)))) != 0) ? 1 : 0;
  endfunction

  task automatic run_op(input int ia, input int ib);
    int lat = 0;
    @(negedge clk);
    a = ia[AW-1:0];
    b = ib[BW-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R4 busy after start", int'(busy), (ib != 0) ? 1 : 0);
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
    if (ib == 0) begin
      chk("R7 latency", lat, 0);
      chk("R7 flag", int'(dbz), 1);
      chk("R7 all ones", int'(quo), (1 << QW) - 1);
      chk("R8 after zero divisor", int'(rem_nz), 0);
    end else begin
      chk("R4 latency", lat, NW);
      chk("R1 R2 R3 quotient", int'(quo), exp_q(ia, ib));
      chk("R8 remainder flag", int'(rem_nz), exp_nz(ia, ib));
      chk("R7 flag clear", int'(dbz), 0);
    end
    @(negedge clk);
    chk("R5 done single cycle", int'(done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R4 watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R10 busy", int'(busy), 0);
    chk("R10 done", int'(done), 0);
    chk("R10 quotient", int'(quo), 0);
    chk("R10 rem_nz", int'(rem_nz), 0);
    chk("R10 div_by_zero", int'(dbz), 0);
    rst_n = 1'b1;

    // worked case: 01.01110 / 1.011 with 5 quotient fraction bits
    @(negedge clk);
    x_a = 7'b0101110;
    x_b = 4'b1011;
    x_start = 1'b1;
    @(negedge clk);
    x_start = 1'b0;
    repeat (12) @(negedge clk);
    chk("R3 worked case done", int'(x_done), 1);
    chk("R3 R2 worked case quotient", int'(x_quo), 13'h1FB7);
    chk("R8 worked case remainder", int'(x_rem_nz), 1);

    // start while busy is ignored
    @(negedge clk);
    a = 6'd13;
    b = 5'd3;
    start = 1'b1;
    @(negedge clk);
    a = 6'b111001;
    b = 5'd0;
    repeat (3) @(negedge clk);
    start = 1'b0;
    repeat (NW - 3) @(negedge clk);
    chk("R6 done of first op", int'(done), 1);
    chk("R6 quotient of first op", int'(quo), exp_q(13, 3));
    chk("R6 no zero-divisor flag", int'(dbz), 0);

    // hold between operations
    repeat (6) @(negedge clk);
    chk("R9 quotient held", int'(quo), exp_q(13, 3));
    chk("R9 rem_nz held", int'(rem_nz), exp_nz(13, 3));
    chk("R5 no extra done", int'(done), 0);

    for (int ia = -32; ia < 32; ia++)
      for (int ib = -16; ib < 16; ib++)
        run_op(ia, ib);

    run_op(7, 0);
    repeat (5) @(negedge clk);
    chk("R9 zero-divisor flag held", int'(dbz), 1);
    run_op(-32, -16);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule